// File: doc/BRIEF.md
# Serial Configuration and Readout Port

This block is the control side of a sampling converter's digital filter. It keeps a 16-bit configuration register and runs a synchronous serial port. The port has an active-low chip select, a serial clock, serial data in and out, a direction input and a word-select input. A write frame of exactly sixteen serial clocks replaces the register contents. A read frame shifts out the 24-bit sample word followed by the 24-bit status word, or the status word alone.

A mode input picks the source of the exported settings. When it is high, the settings come straight from dedicated configuration pins. When it is low, they come from the serial register. Reset loads the register from those pins, so the register starts with the pin settings even when the mode input is low. The exported settings are power-down, test-data select, a 3-bit bandwidth code, the ready-pin drive mode and a 5-bit amplifier select. Power-down does not stop the port, and the register keeps its value through power-down.

The ready output is shown as a value and an output enable. In push-pull mode the pin is always driven. In open-drain mode it is driven high only while ready is asserted.

Top module: `serial_cfg_port`

## Requirements
- R1: With `hs_mode` low, a write frame (`rw`=0) of exactly 16 rising `sclk` edges, sent MSB first while `cs_n` is low, updates the register when `cs_n` rises. The fields are then exported as follows: bit 11 on `pwrdn_o`, bit 10 on `tsel_o`, bits 8..6 on `bw_o`, bit 5 as the ready drive mode (1 = open-drain) and bits 4..0 on `pga_o`. Bits 15..12 and bit 9 are dropped.
- R2: A write frame with any other number of `sclk` edges (for example 15 or 17) leaves the register unchanged.
- R3: While `hs_mode` is high, `pwrdn_o`, `tsel_o`, `bw_o` and `pga_o` follow `hw_pwrdn`, `hw_tsel`, `hw_bw` and `hw_pga`, and the ready pin is push-pull. When `hs_mode` returns low, the serial register value is exported again.
- R4: While `rst` is high, the register loads the hardware pins with drive mode 0. After reset it ignores later pin changes while `hs_mode` is low.
- R5: A read frame (`rw`=1) that starts with `rsel`=1 shifts `data_word` out MSB first and then `stat_word` MSB first on `sdo`, 48 bits in all. Each bit is valid before the rising `sclk` edge that advances it.
- R6: A read frame that starts with `rsel`=0 shifts `stat_word` out MSB first.
- R7: In push-pull mode, `drdy_oe`=1 and `drdy_o`=`drdy_in`. In open-drain mode, `drdy_o`=1 and `drdy_oe`=`drdy_in`.
- R8: While `pwrdn_o` is high, reads and writes work as usual. A write that clears bit 11 ends power-down.
- R9: A read frame leaves the configuration unchanged.
- R10: `sdo` is 0 while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all serial inputs are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | 1 = settings from pins, 0 = settings from the serial register |
| hw_pwrdn | input | 1 | Pin setting: power-down |
| hw_tsel | input | 1 | Pin setting: test-data input select |
| hw_bw | input | 3 | Pin setting: bandwidth code |
| hw_pga | input | 5 | Pin setting: amplifier input/gain select |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; rising edges advance the frame |
| sdi | input | 1 | Serial write data, MSB first |
| rw | input | 1 | Direction, latched at frame start: 1 = read, 0 = write |
| rsel | input | 1 | Read start word, latched at frame start: 1 = sample then status, 0 = status |
| data_word | input | 24 | Sample word, captured at read frame start |
| stat_word | input | 24 | Status word, captured at read frame start |
| drdy_in | input | 1 | Internal ready indication |
| sdo | output | 1 | Serial read data |
| drdy_o | output | 1 | Ready pin value |
| drdy_oe | output | 1 | Ready pin output enable |
| pwrdn_o | output | 1 | Exported power-down |
| tsel_o | output | 1 | Exported test-data select |
| bw_o | output | 3 | Exported bandwidth code |
| pga_o | output | 5 | Exported amplifier select |

## Verification
The bench sends frames that are one clock short and one clock long. A design that commits on any `cs_n` rise, or that counts loosely, would then take a corrupted word. It changes the pins after reset and switches the mode input in both directions, which catches a register that keeps tracking the pins or a mux that sticks. Both read orders are checked bit by bit across the data/status seam, so an off-by-one shift or a swapped word order shows up. Power-down is set and cleared through the port itself, which fails if the port stalls while powered down.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

    localparam int CFG_W  = 16;
    localparam int DATA_W = 24;
    localparam int STAT_W = 24;
    localparam int RD_W   = DATA_W + STAT_W;
    localparam int CNT_W  = $clog2(RD_W) + 1;
    localparam logic [CFG_W-1:0] CFG_USED = 16'h0DFF;

    typedef enum logic {
        XFER_WRITE = 1'b0,
        XFER_READ  = 1'b1
    } xfer_e;

    typedef struct packed {
        logic [3:0] spare_hi;
        logic       pwrdn;
        logic       tsel;
        logic       spare_mid;
        logic [2:0] bw;
        logic       od_mode;
        logic [4:0] pga;
    } cfg_t;

    function automatic cfg_t cfg_from_word(logic [CFG_W-1:0] w);
        return cfg_t'(w & CFG_USED);
    endfunction

    function automatic cfg_t cfg_from_pins(logic pd, logic ts, logic [2:0] bw,
                                           logic [4:0] pga);
        cfg_t c;
        c         = '0;
        c.pwrdn   = pd;
        c.tsel    = ts;
        c.bw      = bw;
        c.od_mode = 1'b0;
        c.pga     = pga;
        return c;
    endfunction

endpackage

// File: rtl/serial_cfg_edge.sv
module serial_cfg_edge #(
    parameter int N = 2,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar i = 0; i < N; i++) begin : g_sig
        always_ff @(posedge clk) begin
            if (rst) q[i] <= IDLE[i];
            else     q[i] <= lvl[i];
        end
        assign rise[i] =  lvl[i] & ~q[i];
        assign fall[i] = ~lvl[i] &  q[i];
    end

endmodule

// File: rtl/serial_cfg_frame.sv
module serial_cfg_frame
    import serial_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              cs_low,
    input  logic              sclk_rise,
    input  logic              sdi,
    input  logic              rw,
    input  logic              rsel,
    input  logic [DATA_W-1:0] data_word,
    input  logic [STAT_W-1:0] stat_word,
    output logic              sdo,
    output logic              commit,
    output logic [CFG_W-1:0]  commit_word,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              is_write
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_CFG = CNT_W'(CFG_W);

    xfer_e            mode_q;
    logic [CFG_W-1:0] wr_sr;
    logic [RD_W-1:0]  rd_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= XFER_WRITE;
            bit_cnt <= '0;
            wr_sr   <= '0;
            rd_sr   <= '0;
        end else if (cs_fall) begin
            mode_q  <= rw ? XFER_READ : XFER_WRITE;
            bit_cnt <= '0;
            rd_sr   <= rsel ? {data_word, stat_word}
                            : {stat_word, {DATA_W{1'b0}}};
        end else if (sclk_rise && cs_low) begin
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            if (mode_q == XFER_WRITE) wr_sr <= {wr_sr[CFG_W-2:0], sdi};
            else                      rd_sr <= {rd_sr[RD_W-2:0], 1'b0};
        end
    end

    assign is_write    = (mode_q == XFER_WRITE);
    assign commit      = cs_rise && is_write && (bit_cnt == CNT_CFG);
    assign commit_word = wr_sr;
    assign sdo         = cs_low && (mode_q == XFER_READ) && rd_sr[RD_W-1];

endmodule

// File: rtl/serial_cfg_select.sv
module serial_cfg_select
    import serial_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_mode,
    input  logic             hw_pwrdn,
    input  logic             hw_tsel,
    input  logic [2:0]       hw_bw,
    input  logic [4:0]       hw_pga,
    input  logic             commit,
    input  logic [CFG_W-1:0] commit_word,
    input  logic             drdy_in,
    output cfg_t             sw_cfg,
    output cfg_t             eff_cfg,
    output logic             drdy_o,
    output logic             drdy_oe
);

    cfg_t pin_cfg;

    assign pin_cfg = cfg_from_pins(hw_pwrdn, hw_tsel, hw_bw, hw_pga);

    always_ff @(posedge clk) begin
        if (rst)         sw_cfg <= pin_cfg;
        else if (commit) sw_cfg <= cfg_from_word(commit_word);
    end

    assign eff_cfg = hs_mode ? pin_cfg : sw_cfg;

    always_comb begin
        if (eff_cfg.od_mode) begin
            drdy_o  = 1'b1;
            drdy_oe = drdy_in;
        end else begin
            drdy_o  = drdy_in;
            drdy_oe = 1'b1;
        end
    end

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import serial_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_mode,
    input  logic              hw_pwrdn,
    input  logic              hw_tsel,
    input  logic [2:0]        hw_bw,
    input  logic [4:0]        hw_pga,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              rw,
    input  logic              rsel,
    input  logic [DATA_W-1:0] data_word,
    input  logic [STAT_W-1:0] stat_word,
    input  logic              drdy_in,
    output logic              sdo,
    output logic              drdy_o,
    output logic              drdy_oe,
    output logic              pwrdn_o,
    output logic              tsel_o,
    output logic [2:0]        bw_o,
    output logic [4:0]        pga_o
);

    logic [1:0]       e_q, e_rise, e_fall;
    logic             cs_rise, cs_fall, cs_low, sclk_rise;
    logic             commit, is_write;
    logic [CFG_W-1:0] commit_word;
    logic [CNT_W-1:0] bit_cnt;
    cfg_t             sw_cfg, eff_cfg;

    serial_cfg_edge #(.N(2), .IDLE(2'b10)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl ({cs_n, sclk}),
        .q   (e_q),
        .rise(e_rise),
        .fall(e_fall)
    );

    assign sclk_rise = e_rise[0];
    assign cs_rise   = e_rise[1];
    assign cs_fall   = e_fall[1];
    assign cs_low    = ~e_q[1];

    serial_cfg_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .cs_low     (cs_low),
        .sclk_rise  (sclk_rise),
        .sdi        (sdi),
        .rw         (rw),
        .rsel       (rsel),
        .data_word  (data_word),
        .stat_word  (stat_word),
        .sdo        (sdo),
        .commit     (commit),
        .commit_word(commit_word),
        .bit_cnt    (bit_cnt),
        .is_write   (is_write)
    );

    serial_cfg_select u_sel (
        .clk        (clk),
        .rst        (rst),
        .hs_mode    (hs_mode),
        .hw_pwrdn   (hw_pwrdn),
        .hw_tsel    (hw_tsel),
        .hw_bw      (hw_bw),
        .hw_pga     (hw_pga),
        .commit     (commit),
        .commit_word(commit_word),
        .drdy_in    (drdy_in),
        .sw_cfg     (sw_cfg),
        .eff_cfg    (eff_cfg),
        .drdy_o     (drdy_o),
        .drdy_oe    (drdy_oe)
    );

    assign pwrdn_o = eff_cfg.pwrdn;
    assign tsel_o  = eff_cfg.tsel;
    assign bw_o    = eff_cfg.bw;
    assign pga_o   = eff_cfg.pga;

endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk
    import serial_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hs_mode,
    input logic             hw_pwrdn,
    input logic [2:0]       hw_bw,
    input logic [4:0]       hw_pga,
    input logic             cs_n,
    input logic             cs_rise,
    input logic             is_write,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [CFG_W-1:0] sw_cfg,
    input logic             drdy_in,
    input logic             drdy_o,
    input logic             drdy_oe,
    input logic             sdo,
    input logic             pwrdn_o,
    input logic [2:0]       bw_o,
    input logic [4:0]       pga_o
);

    // R1 and R2: the register moves only after a 16-clock write frame closes
    a_r2_commit_only_16: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(sw_cfg)) |->
            $past(cs_rise && is_write && (bit_cnt == CNT_W'(16))));

    a_r9_read_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(is_write) == 1'b0)) |-> $stable(sw_cfg));

    a_r3_pins_follow: assert property (@(posedge clk) disable iff (rst)
        hs_mode |-> (pwrdn_o == hw_pwrdn && bw_o == hw_bw && pga_o == hw_pga));

    a_r7_push_pull: assert property (@(posedge clk) disable iff (rst)
        (hs_mode || !sw_cfg[5]) |-> (drdy_oe && drdy_o == drdy_in));

    a_r7_open_drain: assert property (@(posedge clk) disable iff (rst)
        (!hs_mode && sw_cfg[5]) |-> (drdy_o && drdy_oe == drdy_in));

    a_r10_sdo_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !sdo);

endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .hs_mode (hs_mode),
    .hw_pwrdn(hw_pwrdn),
    .hw_bw   (hw_bw),
    .hw_pga  (hw_pga),
    .cs_n    (cs_n),
    .cs_rise (cs_rise),
    .is_write(is_write),
    .bit_cnt (bit_cnt),
    .sw_cfg  (sw_cfg),
    .drdy_in (drdy_in),
    .drdy_o  (drdy_o),
    .drdy_oe (drdy_oe),
    .sdo     (sdo),
    .pwrdn_o (pwrdn_o),
    .bw_o    (bw_o),
    .pga_o   (pga_o)
);

// File: tb/test_serial_cfg_port.sv
`timescale 1ns/1ps
module test_serial_cfg_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_mode = 1'b0;
    logic        hw_pwrdn = 1'b0, hw_tsel = 1'b1;
    logic [2:0]  hw_bw = 3'b101;
    logic [4:0]  hw_pga = 5'h13;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, rw = 1'b0, rsel = 1'b0;
    logic [23:0] data_word = 24'hA5C31E;
    logic [23:0] stat_word = 24'h5A0F33;
    logic        drdy_in = 1'b0;
    logic        sdo, drdy_o, drdy_oe, pwrdn_o, tsel_o;
    logic [2:0]  bw_o;
    logic [4:0]  pga_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    serial_cfg_port i_serial_cfg_port (
        .clk(clk), .rst(rst), .hs_mode(hs_mode), .hw_pwrdn(hw_pwrdn),
        .hw_tsel(hw_tsel), .hw_bw(hw_bw), .hw_pga(hw_pga), .cs_n(cs_n),
        .sclk(sclk), .sdi(sdi), .rw(rw), .rsel(rsel), .data_word(data_word),
        .stat_word(stat_word), .drdy_in(drdy_in), .sdo(sdo), .drdy_o(drdy_o),
        .drdy_oe(drdy_oe), .pwrdn_o(pwrdn_o), .tsel_o(tsel_o), .bw_o(bw_o),
        .pga_o(pga_o)
    );

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // field view of the outputs; valid with drdy_in low (oe low means open-drain)
    task automatic check_cfg(string tag, logic [15:0] w);
        check(tag, {32'h0, 4'h0, pwrdn_o, tsel_o, 1'b0, bw_o, ~drdy_oe, pga_o},
              {32'h0, w & 16'h0DFF});
    endtask

    task automatic write_bits(logic [31:0] v, int nbits);
        cs_n = 1'b0; rw = 1'b0;
        wait_clk(2);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = v[i];
            wait_clk(1);
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
            wait_clk(1);
        end
        cs_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic read_bits(logic sel, int nbits, output logic [47:0] got);
        got = '0;
        cs_n = 1'b0; rw = 1'b1; rsel = sel;
        wait_clk(2);
        for (int i = 0; i < nbits; i++) begin
            got = {got[46:0], sdo};
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
            wait_clk(2);
        end
        cs_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic t_reset();
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        check_cfg("R4 reset loads pins", 16'h0553);
        check("R10 sdo idle after reset", {47'h0, sdo}, 48'h0);
        check("R7 push-pull after reset", {46'h0, drdy_oe, drdy_o}, 48'h2);
        hw_bw = 3'b000; hw_pga = 5'h01; hw_tsel = 1'b0;
        wait_clk(2);
        check_cfg("R4 pins ignored after reset", 16'h0553);
    endtask

    task automatic t_write();
        write_bits(32'hF6AA, 16);
        check_cfg("R1 16-bit write commit", 16'h04AA);
    endtask

    task automatic t_open_drain();
        drdy_in = 1'b1;
        wait_clk(1);
        check("R7 open-drain ready high", {46'h0, drdy_oe, drdy_o}, 48'h3);
        drdy_in = 1'b0;
        wait_clk(1);
        check("R7 open-drain ready low", {46'h0, drdy_oe, drdy_o}, 48'h1);
    endtask

    task automatic t_bad_length();
        write_bits(32'h0123, 15);
        check_cfg("R2 15-clock write ignored", 16'h04AA);
        write_bits(32'h10123, 17);
        check_cfg("R2 17-clock write ignored", 16'h04AA);
    endtask

    task automatic t_hw_mode();
        hw_pwrdn = 1'b1; hw_tsel = 1'b0; hw_bw = 3'b011; hw_pga = 5'h1F;
        hs_mode = 1'b1;
        wait_clk(1);
        check_cfg("R3 pin mode follows pins", 16'h08DF);
        hw_bw = 3'b110; hw_pga = 5'h02;
        wait_clk(1);
        check_cfg("R3 pin mode tracks change", 16'h0982);
        hs_mode = 1'b0;
        wait_clk(1);
        check_cfg("R3 back to serial register", 16'h04AA);
    endtask

    task automatic t_read();
        logic [47:0] got;
        read_bits(1'b1, 48, got);
        check("R5 data then status", got, {data_word, stat_word});
        check_cfg("R9 read keeps config", 16'h04AA);
        read_bits(1'b0, 24, got);
        check("R6 status only", got, {24'h0, stat_word});
        check("R10 sdo idle after read", {47'h0, sdo}, 48'h0);
    endtask

    task automatic t_power_down();
        logic [47:0] got;
        write_bits(32'h0B47, 16);
        check_cfg("R8 power-down by write", 16'h0947);
        data_word = 24'h13579B; stat_word = 24'hFEDCBA;
        read_bits(1'b1, 48, got);
        check("R8 read while powered down", got, {24'h13579B, 24'hFEDCBA});
        write_bits(32'h087C, 16);
        check_cfg("R8 write while powered down", 16'h087C);
        write_bits(32'h007C, 16);
        check_cfg("R8 power-down cleared", 16'h007C);
    endtask

    initial begin
        t_reset();
        t_write();
        t_open_drain();
        t_bad_length();
        t_hw_mode();
        t_read();
        t_power_down();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule